// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block is a clocked front end for a one-bit-wide asynchronous static RAM with 1,048,576 locations, separate data-in and data-out pins, and active-low select and write strobes. A client hands it single-word requests: a read/write flag, a 20-bit address and, for writes, one data bit. The controller turns each request into a pin sequence on the memory side. For reads it returns the sampled bit together with a one-cycle valid strobe.

Every analog limit of the memory is a nanosecond parameter. Each one becomes a cycle count at elaboration: the ceiling of the limit divided by the clock period, with a floor of one cycle. A single down-counter times every phase. All memory-side pins come straight from flops. Between requests the chip is deselected, which keeps the part in its low-power state.

The request side is a valid/ready channel. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low for the whole memory sequence, so a client holding `req_valid` simply waits. The client must keep the request fields stable until the transfer. The read return has no back-pressure: the consumer must take `rd_data` in the cycle `rd_valid` is high.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `mem_ce_n` is 1, `mem_we_n` is 1 and `rd_valid` is 0.
- R2: A write stores `req_wdata` at `req_addr` in the memory, and a later read of that address returns it on `rd_data`. This holds for addresses 0x00000, 0xFFFFF and mixed bit patterns.
- R3: A write first drives address and data with `mem_ce_n` low and `mem_we_n` high for one cycle. It then holds `mem_we_n` low for the pulse count, which is 2 cycles at the default parameters. `mem_we_n` is never low while `mem_ce_n` is high.
- R4: A write ends with `mem_we_n` rising while `mem_ce_n` is still low. Address and data are then held one more cycle before deselect, so `req_ready` is low for 4 cycles per write at the defaults.
- R5: A read holds `mem_ce_n` low and `mem_we_n` high with a fixed address. It samples `mem_dout` only after the access count, which is 2 cycles at the defaults. `rd_valid` rises 2 cycles after the accepting edge.
- R6: The first read after a write waits the recovery count on top of the access count, 1 extra cycle at the defaults. A read that follows a read does not wait.
- R7: `rd_valid` is high for exactly one cycle per read, carrying the sampled bit on `rd_data`.
- R8: Each handshake starts exactly one memory operation. `req_ready` drops on the cycle after a transfer, so a request held valid across a busy period is not taken twice.
- R9: Whenever `req_ready` is high, `mem_ce_n` is high (the chip is deselected while idle).
- R10: While `mem_ce_n` stays low, `mem_addr` and `mem_din` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request accepted this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 1 | Write data bit |
| rd_valid | output | 1 | One-cycle strobe, read data present |
| rd_data | output | 1 | Sampled read bit |
| mem_addr | output | 20 | Memory address pins |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_din | output | 1 | Memory data-in pin |
| mem_dout | input | 1 | Memory data-out pin |

## Verification
The assertions watch the pin discipline on every cycle:
- the write strobe only falls inside a select window;
- the write strobe rises before deselect;
- address and data stay stable while selected;
- the chip is deselected when idle;
- ready drops after each transfer;
- the read strobe is a single pulse.

Only the bench's scenarios can show the counted durations: the strobe width, the busy length, the read latency and the extra post-write recovery. They also show that data lands in the right location. The bench memory model outputs the inverted bit until the access time has elapsed, so a read sampled too early returns the wrong value.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RWAIT  = 3'd4
  } seq_state_t;

  // ceiling of ns / period, never below one cycle
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val - 1'b1;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // phase durations rely on a strict one-per-cycle countdown (R5)
  assert_timer_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = 20,
  parameter int CNT_W   = 3,
  parameter int PULSE_C = 2,
  parameter int HOLD_C  = 1,
  parameter int RD_C    = 2,
  parameter int RCV_C   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_wdata,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_ce_n,
  output logic             mem_we_n,
  output logic             mem_din,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  input  logic             tmr_expired,
  output logic             cap_en
);

  localparam logic [CNT_W-1:0] PULSE_V  = CNT_W'(PULSE_C);
  localparam logic [CNT_W-1:0] HOLD_V   = CNT_W'(HOLD_C);
  localparam logic [CNT_W-1:0] RD_V     = CNT_W'(RD_C);
  localparam logic [CNT_W-1:0] RD_RCV_V = CNT_W'(RD_C + RCV_C);

  seq_state_t state;
  logic       rcv_pend;
  logic       take;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_valid && req_ready;
  assign cap_en    = (state == ST_RWAIT) && tmr_expired;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      ST_IDLE: if (take && !req_write) begin
        tmr_load = 1'b1;
        tmr_val  = rcv_pend ? RD_RCV_V : RD_V;
      end
      ST_WSETUP: begin
        tmr_load = 1'b1;
        tmr_val  = PULSE_V;
      end
      ST_WPULSE: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = HOLD_V;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mem_addr <= '0;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_din  <= 1'b0;
      rcv_pend <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (take) begin
          mem_addr <= req_addr;
          mem_ce_n <= 1'b0;
          mem_we_n <= 1'b1;
          if (req_write) begin
            mem_din <= req_wdata;
            state   <= ST_WSETUP;
          end else begin
            rcv_pend <= 1'b0;
            state    <= ST_RWAIT;
          end
        end
        ST_WSETUP: begin
          mem_we_n <= 1'b0;
          state    <= ST_WPULSE;
        end
        ST_WPULSE: if (tmr_expired) begin
          mem_we_n <= 1'b1;
          state    <= ST_WHOLD;
        end
        ST_WHOLD: if (tmr_expired) begin
          mem_ce_n <= 1'b1;
          rcv_pend <= 1'b1;
          state    <= ST_IDLE;
        end
        ST_RWAIT: if (tmr_expired) begin
          mem_ce_n <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_we_inside_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  assert_we_ends_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_ce_n);

  assert_one_op_per_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);

  assert_idle_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);

  assert_pins_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_din)));

endmodule

// File: rtl/sram_read_capture.sv
module sram_read_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic mem_dout,
  output logic rd_valid,
  output logic rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 1'b0;
    end else begin
      rd_valid <= cap_en;
      if (cap_en) rd_data <= mem_dout;
    end
  end

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 20,
  parameter int CLK_NS    = 10,
  parameter int T_WC_NS   = 15,
  parameter int T_PWE_NS  = 12,
  parameter int T_SD_NS   = 8,
  parameter int T_AW_NS   = 12,
  parameter int T_SCE_NS  = 12,
  parameter int T_RC_NS   = 15,
  parameter int T_AA_NS   = 15,
  parameter int T_LZWE_NS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic          req_wdata,
  output logic          rd_valid,
  output logic          rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_din,
  input  logic          mem_dout
);

  // the setup cycle already counts toward address/select-to-end limits
  localparam int PULSE_C = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)),
                                imax(ns_to_cyc(T_AW_NS, CLK_NS) - 1, ns_to_cyc(T_SCE_NS, CLK_NS) - 1));
  localparam int HOLD_C  = imax(1, ns_to_cyc(T_WC_NS, CLK_NS) - 1 - PULSE_C);
  localparam int RD_C    = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int RCV_C   = ns_to_cyc(T_LZWE_NS, CLK_NS);
  localparam int MAX_C   = imax(imax(PULSE_C, HOLD_C), RD_C + RCV_C);
  localparam int CNT_W   = $clog2(MAX_C + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             cap_en;

  sram_seq_ctrl #(
    .AW(AW), .CNT_W(CNT_W), .PULSE_C(PULSE_C),
    .HOLD_C(HOLD_C), .RD_C(RD_C), .RCV_C(RCV_C)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_din(mem_din),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .tmr_expired(tmr_expired),
    .cap_en(cap_en)
  );

  sram_wait_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .load_val(tmr_val), .expired(tmr_expired)
  );

  sram_read_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .cap_en(cap_en), .mem_dout(mem_dout),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

endmodule

// File: tb/sim_sram_async_ctrl.sv
module sim_sram_async_ctrl;

  localparam int CLK = 10;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction

  // expectations from the requirement timings (15 ns grade, 10 ns clock)
  localparam int EXP_PULSE = 2;                  // R3
  localparam int EXP_BUSY  = 4;                  // R4
  localparam int EXP_RD    = 2;                  // R5
  localparam int EXP_RCV   = 1;                  // R6

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_wdata = 1'b0;
  logic        req_ready, rd_valid, rd_data;
  logic [19:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_din;
  logic        mdout = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #(CLK/2) clk = ~clk;

  sram_async_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_din(mem_din), .mem_dout(mdout)
  );

  // memory model: evaluated mid-cycle; returns the inverted bit until access time passed
  bit          store [int unsigned];
  logic [21:0] prev_pins = '1;
  logic        prev_din = 1'b0;
  int          age = 0;
  int          ce_falls = 0;

  function automatic bit peek(input logic [19:0] a);
    return store.exists(int'(a)) ? store[int'(a)] : 1'b0;
  endfunction

  always @(negedge clk) begin
    logic [21:0] now_pins;
    int          nage;
    now_pins = {mem_addr, mem_ce_n, mem_we_n};
    nage = (now_pins != prev_pins) ? 1 : age + 1;
    if (!prev_pins[1] && !prev_pins[0] && (mem_we_n || mem_ce_n))
      store[int'(prev_pins[21:2])] = prev_din;
    if (prev_pins[1] && !mem_ce_n) ce_falls++;
    if (!mem_ce_n && mem_we_n && nage * CLK >= 15) mdout <= peek(mem_addr);
    else                                            mdout <= ~peek(mem_addr);
    age       <= nage;
    prev_pins <= now_pins;
    prev_din  <= mem_din;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // issue one request; returns cycles with ready low, strobe-low cycles, read latency
  task automatic issue(input bit wr, input logic [19:0] a, input bit d,
                       output int busy, output int we_low, output int lat, output bit rdat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0; we_low = 0; lat = 0; rdat = 1'b0;
    while (!req_ready) begin
      busy++;
      if (!mem_we_n) we_low++;
      @(negedge clk);
    end
    if (!wr) begin
      lat = busy;
      check(rd_valid == 1'b1, "R5 rd_valid at ready", rd_valid, 1);
      rdat = rd_data;
      @(negedge clk);
      check(rd_valid == 1'b0, "R7 rd_valid single cycle", rd_valid, 0);
    end
  endtask

  task automatic t_reset;
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(mem_ce_n == 1'b1, "R1 ce_n", mem_ce_n, 1);
    check(mem_we_n == 1'b1, "R1 we_n", mem_we_n, 1);
    check(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
  endtask

  task automatic t_write_read(input logic [19:0] a, input bit d);
    int b, w, l; bit r;
    issue(1'b1, a, d, b, w, l, r);
    check(w == EXP_PULSE, "R3 we_n low cycles", w, EXP_PULSE);
    check(b == EXP_BUSY, "R4 write busy cycles", b, EXP_BUSY);
    check(peek(a) == d, "R2 stored bit", peek(a), d);
    issue(1'b0, a, 1'b0, b, w, l, r);
    check(l == EXP_RD + EXP_RCV, "R6 read after write latency", l, EXP_RD + EXP_RCV);
    check(r == d, "R2 readback", r, d);
    issue(1'b0, a, 1'b0, b, w, l, r);
    check(l == EXP_RD, "R5 read after read latency", l, EXP_RD);
    check(r == d, "R5 second readback", r, d);
  endtask

  task automatic t_setup_phase;
    // R3: first cycle after accept has ce low, we high, address on pins
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h0F0F0; req_wdata = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!mem_ce_n && mem_we_n, "R3 setup cycle", {mem_ce_n, mem_we_n}, 2'b01);
    check(mem_addr == 20'h0F0F0, "R10 address driven", mem_addr, 20'h0F0F0);
    while (!req_ready) @(negedge clk);
    check(mem_ce_n == 1'b1, "R9 idle deselected", mem_ce_n, 1);
  endtask

  task automatic t_backpressure;
    int f0; bit r; int b, w, l;
    f0 = ce_falls;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h12345; req_wdata = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_addr = 20'h54321; req_wdata = 1'b0;   // valid held through busy period
    check(req_ready == 1'b0, "R8 ready low after take", req_ready, 0);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    check(ce_falls - f0 == 2, "R8 ops per two handshakes", ce_falls - f0, 2);
    check(peek(20'h12345) == 1'b1, "R8 first write", peek(20'h12345), 1);
    check(peek(20'h54321) == 1'b0, "R8 second write", peek(20'h54321), 0);
    issue(1'b0, 20'h12345, 1'b0, b, w, l, r);
    check(r == 1'b1, "R2 readback after back-pressure", r, 1);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    store[int'(20'h00000)] = 1'b1;  // preset so a zero write is visible
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read(20'h00000, 1'b0);
    t_write_read(20'hFFFFF, 1'b1);
    t_write_read(20'h55555, 1'b1);
    t_write_read(20'hAAAAA, 1'b0);
    t_write_read(20'h55555, 1'b0);
    t_setup_phase();
    t_backpressure();
    check(cyc(12) == EXP_PULSE, "R3 derived pulse count", cyc(12), EXP_PULSE);
    finish_run();
  end

endmodule